// File: doc/BRIEF.md
# Folded Distributed-Arithmetic FIR Filter

This block is a 65-tap FIR filter with a fixed, symmetric coefficient set and no multipliers. Each accepted 12-bit two's-complement sample enters a delay line. Taps that share a coefficient (tap k and tap 64-k) are summed in 13-bit pre-adders, so only 33 coefficient products are formed. The pre-added words are then fed two bits per clock, least significant pair first, into small coefficient-sum tables. Each table sees one bit of each of four pre-added taps and returns the sum of the coefficients whose bits are set. The one tap left over after grouping by four has no table: its contribution is an AND of that bit with its coefficient.

One table bank serves the low bit of the pair and a second bank serves the high bit, which is weighted by two. A full-precision accumulator shifts right by two bits each clock. The top bit of the last digit carries negative weight, so its partial sum is subtracted, which gives two's-complement scaling. A result takes seven clocks, and the next sample may be accepted on the same edge that finishes the current one.

The input is a valid/ready stream. The output has no back-pressure: `out_valid` pulses for one cycle, the consumer must capture the result in that cycle, and `out_data` holds its value until the next result. The coefficient set is a packed parameter holding the 33 unique values, 10 bits each, with index 0 in the least significant slice.

Top module: `fir_da_folded`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0, `out_data` is 0, and every delay-line entry is zero, so the first result after reset equals h[0] times the first sample.
- R2: A sample is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 for the six cycles that follow, so two acceptances are at least 7 edges apart, and exactly 7 when the source is always valid.
- R3: Raising `in_valid` while `in_ready` is 0 has no effect: the sample does not enter the delay line, and no later result contains it.
- R4: For each accepted sample, `out_valid` is 1 for exactly one cycle, starting with the 7th rising edge after the accepting edge. It never pulses without an accepted sample.
- R5: `out_data` is the 29-bit two's-complement value of sum over k = 0..64 of h[k]*x[n-k], where x[n] is the newest sample, h[k] = h[64-k] = COEFS slice k for k <= 32, and samples older than reset count as zero.
- R6: `out_data` changes only in a cycle where `out_valid` is 1 and keeps its value between pulses.
- R7: Full-scale inputs (all 2047, all -2048, or 2047 and -2048 alternating) on every tap give the exact result, with no wrap in the pre-adders or the accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Filter can take a sample this cycle |
| in_data | input | 12 | Sample, two's complement |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_data | output | 29 | Filtered result, two's complement, held between pulses |

## Verification
A unit impulse pushed through the full delay line brings out each coefficient on its own, in tap order. This shows whether the pre-adders pair the right taps, whether the tables are filled correctly, and whether the single AND-gated tap and the sign-digit subtraction are right. Constant and alternating full-scale inputs drive every pre-adder and the accumulator to their extremes, and these are the cases that expose a missing width or a wrong sign extension. A long pseudo-random stream, a burst of strobes while the filter is busy, and a reset in the middle of the run check the general arithmetic, the input that must be ignored, and the clearing of the history.

// File: rtl/fir_da_pkg.sv
package fir_da_pkg;

  localparam int DEF_UNIQUE = 33;
  localparam int DEF_CW     = 10;

  // Default symmetric half-set: a spread of mixed-sign values and a large centre tap.
  function automatic logic [DEF_UNIQUE*DEF_CW-1:0] default_coefs();
    logic [DEF_UNIQUE*DEF_CW-1:0] r;
    int v;
    r = '0;
    for (int k = 0; k < DEF_UNIQUE; k++) begin
      v = ((k * 37 + 11) % 201) - 100;
      if (k == DEF_UNIQUE - 1) v = 511;
      r[k*DEF_CW +: DEF_CW] = v[DEF_CW-1:0];
    end
    return r;
  endfunction

endpackage

// File: rtl/fir_da_lut.sv
// Four-input coefficient-sum table: entry a holds the sum of the coefficients whose address bit is set.
module fir_da_lut #(
  parameter int CW = 10,
  parameter int TW = 12,
  parameter logic signed [CW-1:0] C0 = '0,
  parameter logic signed [CW-1:0] C1 = '0,
  parameter logic signed [CW-1:0] C2 = '0,
  parameter logic signed [CW-1:0] C3 = '0
) (
  input  logic [3:0]           addr,
  output logic signed [TW-1:0] psum
);

  logic signed [TW-1:0] rom [16];

  for (genvar a = 0; a < 16; a++) begin : g_ent
    localparam logic signed [TW-1:0] ENT =
        ((((a >> 0) & 1) != 0) ? TW'(C0) : TW'(0)) +
        ((((a >> 1) & 1) != 0) ? TW'(C1) : TW'(0)) +
        ((((a >> 2) & 1) != 0) ? TW'(C2) : TW'(0)) +
        ((((a >> 3) & 1) != 0) ? TW'(C3) : TW'(0));
    assign rom[a] = ENT;
  end

  assign psum = rom[addr];

endmodule

// File: rtl/fir_da_plane.sv
// One bit plane: the unique taps grouped by four into tables, a single leftover tap gated by AND.
module fir_da_plane #(
  parameter int NU = 33,
  parameter int CW = 10,
  parameter int TW = 12,
  parameter int PW = 17,
  parameter int NG = (NU + 3) / 4,
  parameter logic [NG*4*CW-1:0] CPAD = '0
) (
  input  logic [NU-1:0]        bits,
  output logic signed [PW-1:0] psum
);

  logic signed [TW-1:0] part [NG];

  for (genvar g = 0; g < NG; g++) begin : g_grp
    localparam int NIN = ((NU - 4*g) >= 4) ? 4 : (NU - 4*g);
    if (NIN == 1) begin : g_and
      assign part[g] = bits[4*g] ? TW'($signed(CPAD[(4*g)*CW +: CW])) : TW'(0);
    end else begin : g_tbl
      logic [3:0] addr;
      for (genvar j = 0; j < 4; j++) begin : g_bit
        if (4*g + j < NU) begin : g_live
          assign addr[j] = bits[4*g + j];
        end else begin : g_tie
          assign addr[j] = 1'b0;
        end
      end
      fir_da_lut #(
        .CW(CW), .TW(TW),
        .C0($signed(CPAD[(4*g+0)*CW +: CW])),
        .C1($signed(CPAD[(4*g+1)*CW +: CW])),
        .C2($signed(CPAD[(4*g+2)*CW +: CW])),
        .C3($signed(CPAD[(4*g+3)*CW +: CW]))
      ) u_lut (
        .addr (addr),
        .psum (part[g])
      );
    end
  end

  always_comb begin
    psum = '0;
    for (int g = 0; g < NG; g++) psum = psum + PW'(part[g]);
  end

endmodule

// File: rtl/fir_da_fold.sv
// Delay line, symmetric pre-adders and the two-bit-per-clock serializers.
module fir_da_fold #(
  parameter int NTAPS = 65,
  parameter int DW    = 12,
  parameter int NU    = (NTAPS + 1) / 2,
  parameter int SRW   = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 step,
  input  logic signed [DW-1:0] sample,
  output logic [NU-1:0]        bit_lo,
  output logic [NU-1:0]        bit_hi
);

  logic signed [DW-1:0]  line_q [NTAPS];
  logic signed [DW-1:0]  nl     [NTAPS];
  logic signed [SRW-1:0] pre    [NU];
  logic [SRW-1:0]        sr_q   [NU];

  always_comb begin
    nl[0] = sample;
    for (int i = 1; i < NTAPS; i++) nl[i] = line_q[i-1];
  end

  for (genvar k = 0; k < NU; k++) begin : g_pre
    if (k == NTAPS - 1 - k) begin : g_mid
      assign pre[k] = SRW'(nl[k]);
    end else begin : g_pair
      assign pre[k] = SRW'(nl[k]) + SRW'(nl[NTAPS-1-k]);
    end
    assign bit_lo[k] = sr_q[k][0];
    assign bit_hi[k] = sr_q[k][1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTAPS; i++) line_q[i] <= '0;
      for (int k = 0; k < NU; k++)    sr_q[k]   <= '0;
    end else if (load) begin
      for (int i = 0; i < NTAPS; i++) line_q[i] <= nl[i];
      for (int k = 0; k < NU; k++)    sr_q[k]   <= pre[k];
    end else if (step) begin
      for (int k = 0; k < NU; k++)    sr_q[k]   <= sr_q[k] >> 2;
    end
  end

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(line_q[0])); // R3

endmodule

// File: rtl/fir_da_folded.sv
module fir_da_folded #(
  parameter int NTAPS = 65,
  parameter int DW    = 12,
  parameter int CW    = 10,
  parameter logic [((NTAPS+1)/2)*CW-1:0] COEFS = fir_da_pkg::default_coefs(),
  parameter int OW    = DW + CW + $clog2(NTAPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [OW-1:0] out_data
);

  localparam int NU   = (NTAPS + 1) / 2;
  localparam int NG   = (NU + 3) / 4;
  localparam int ND   = (DW + 2) / 2;
  localparam int SRW  = 2 * ND;
  localparam int TW   = CW + 2;
  localparam int PW   = CW + $clog2(NU) + 1;
  localparam int DSW  = PW + 2;
  localparam int SH   = 2 * (ND - 1);
  localparam int AW   = DSW + SH + 1;
  localparam int CNTW = $clog2(ND);
  localparam logic [NG*4*CW-1:0] CPAD = (NG*4*CW)'(COEFS);

  logic            busy_q;
  logic [CNTW-1:0] cnt_q;
  logic            last, first, accept;
  logic [NU-1:0]   bit_lo, bit_hi;
  logic signed [PW-1:0]  p_lo, p_hi;
  logic signed [DSW-1:0] hi2, dsum;
  logic signed [AW-1:0]  acc_q, acc_base, acc_next;

  assign last     = busy_q && (cnt_q == CNTW'(ND - 1));
  assign first    = (cnt_q == '0);
  assign in_ready = !busy_q || last;
  assign accept   = in_valid && in_ready;

  fir_da_fold #(.NTAPS(NTAPS), .DW(DW), .NU(NU), .SRW(SRW)) u_fold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .step   (busy_q),
    .sample ($signed(in_data)),
    .bit_lo (bit_lo),
    .bit_hi (bit_hi)
  );

  fir_da_plane #(.NU(NU), .CW(CW), .TW(TW), .PW(PW), .NG(NG), .CPAD(CPAD)) u_plane_lo (
    .bits (bit_lo),
    .psum (p_lo)
  );

  fir_da_plane #(.NU(NU), .CW(CW), .TW(TW), .PW(PW), .NG(NG), .CPAD(CPAD)) u_plane_hi (
    .bits (bit_hi),
    .psum (p_hi)
  );

  // Digit sum: high plane weighted by two; the top bit of the final digit carries negative weight.
  always_comb begin
    hi2 = DSW'(p_hi) <<< 1;
    if (last) dsum = DSW'(p_lo) - hi2;
    else      dsum = DSW'(p_lo) + hi2;
    if (first) acc_base = '0;
    else       acc_base = acc_q >>> 2;
    acc_next = acc_base + (AW'(dsum) <<< SH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      acc_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (last) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q  <= cnt_q + 1'b1;
      end
      if (busy_q) acc_q <= acc_next;
      out_valid <= last;
      if (last) out_data <= OW'(acc_next);
    end
  end

  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R2

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R4

  AST_PULSE_FROM_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(busy_q)); // R4

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data)); // R6

endmodule

// File: tb/fir_da_folded_tb_top.sv
module fir_da_folded_tb_top;

  localparam int NT = 65;
  localparam int DW = 12;
  localparam int CW = 10;
  localparam int NU = 33;
  localparam int OW = 29;

  localparam int BC [NU] = '{-3, 0, 5, 7, 2, -8, -14, -9, 6, 21, 24, 7, -22, -41, -33, 4,
                             45, 62, 38, -19, -75, -96, -51, 42, 131, 163, 95, -40, -160,
                             -190, -512, 300, 511};

  function automatic logic [NU*CW-1:0] pack_c();
    logic [NU*CW-1:0] r;
    for (int i = 0; i < NU; i++) r[i*CW +: CW] = CW'(BC[i]);
    return r;
  endfunction

  localparam logic [NU*CW-1:0] BCOEF = pack_c();

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [DW-1:0] in_data;
  logic          out_valid;
  logic [OW-1:0] out_data;

  always #2 clk = ~clk;

  fir_da_folded #(.NTAPS(NT), .DW(DW), .CW(CW), .COEFS(BCOEF), .OW(OW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  int     checks = 0;
  int     fails  = 0;
  int     cyc    = 0;
  bit     done   = 1'b0;
  bit     gap_en = 1'b0;
  int     last_acc = 0;
  longint hist [NT];
  longint exp_q [$];
  int     due_q [$];
  string  tag_q [$];
  logic [OW-1:0] last_out = '0;
  int unsigned seed = 32'h1234_5678;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic longint coef(input int k);
    return longint'(BC[(k < NU) ? k : (NT - 1 - k)]);
  endfunction

  // Driver: offers one sample, pushes the expected result once the sample is taken.
  task automatic send(input int s, input string tag);
    longint e;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = DW'(s);
    for (int i = NT - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = longint'(s);
    e = 0;
    for (int k = 0; k < NT; k++) e += coef(k) * hist[k];
    exp_q.push_back(e);
    due_q.push_back(cyc + 8);
    tag_q.push_back(tag);
    if (gap_en) check((cyc + 1 - last_acc) == 7, "R2", "accept spacing", cyc + 1 - last_acc, 7);
    last_acc = cyc + 1;
    gap_en   = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) % 4096) - 2048;
  endfunction

  // Monitor: pops expected results as out_valid pulses arrive.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", "pulse with no accepted sample", 1, 0);
        end else begin
          longint e;
          int     d;
          string  t;
          e = exp_q.pop_front();
          d = due_q.pop_front();
          t = tag_q.pop_front();
          check(longint'($signed(out_data)) == e, t, "filter output",
                longint'($signed(out_data)), e);
          check(cyc == d, "R4", "pulse cycle", cyc, d);
        end
        last_out <= out_data;
      end else begin
        check(out_data == last_out, "R6", "hold between pulses",
              longint'($signed(out_data)), longint'($signed(last_out)));
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NT; i++) hist[i] = 0;
    last_out = '0;
    gap_en   = 1'b0;
    rst_n    = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);
    check(out_valid == 1'b0, "R1", "valid after reset", out_valid, 0);
    check(out_data == '0, "R1", "data after reset", longint'($signed(out_data)), 0);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    do_reset();

    // Impulse: each coefficient appears on its own, tap 0 first (R5)
    send(1, "R5");
    for (int i = 0; i < NT; i++) send(0, "R5");

    // Full scale (R7)
    for (int i = 0; i < NT; i++) send(2047, "R7");
    for (int i = 0; i < NT; i++) send(-2048, "R7");
    for (int i = 0; i < NT; i++) send((i % 2 == 0) ? 2047 : -2048, "R7");

    // Random stream (R5)
    for (int i = 0; i < 40; i++) send(rnd(), "R5");

    // Strobes while busy must be ignored (R3); ready stays low meanwhile (R2)
    send(rnd(), "R3");
    for (int i = 0; i < 4; i++) begin
      check(in_ready == 1'b0, "R2", "ready low while busy", in_ready, 0);
      in_valid = 1'b1;
      in_data  = DW'(777);
      @(negedge clk);
    end
    in_valid = 1'b0;
    gap_en   = 1'b0;
    for (int i = 0; i < 8; i++) send(0, "R3");
    for (int i = 0; i < 40; i++) send(rnd(), "R5");
    drain();

    // Reset in the middle of the run clears the history (R1)
    do_reset();
    send(-5, "R1");
    send(3, "R1");
    for (int i = 0; i < 6; i++) send(rnd(), "R5");
    drain();

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule